// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns the primary bus address and its three space strobes (program, data, I/O) into one select for an on-chip memory and five selects for devices on an external bus. Seven 16-bit configuration words control the decode. Each one holds a compare value and a set of per-space disable bits, and a select fires only when both allow it. The selects are active low and combinational, so they follow the address and strobes within the same cycle.

The configuration words sit in I/O space inside a window of seven consecutive 256-byte pages. The base page of the window is taken from the secondary address byte on a rising edge of the programming strobe. When an I/O access lands in the window, the addressed word can be read on the readback bus and written from the primary data bus. While an access is in the window, all external selects are held off, so no external device can answer an access to the decoder's own registers. External ranges have 8KB granularity. The on-chip memory is split into two 32KB halves, and each half belongs to either data space or program space.

Top module: `csdec`

## Requirements
- R1: Reset (rst_n low) sets every configuration word to 16'hFFFF and the window base to 8'h00. Every select reads high (inactive) and rdata reads 0 while no access is in the window.
- R2: The window base is loaded from sa_hi at the first rising clock edge that samples prog high after sampling it low. The new base applies from that edge on.
- R3: An access is in the window when is_n is low and (pa[15:8] - base) mod 256 is 0 to 6. That difference is the word index k. While in the window, rdata shows word k. Outside the window, rdata is 0.
- R4: A rising clock edge with an in-window access, iostrb_n low and rw low (rw=0 means write) loads pd into word k. When iostrb_n is high or rw is high, the word keeps its value.
- R5: Word 0 drives int_sel_n. Its bits 6:0 are compared against pa[21:15]. When bit 7 is set, only bits 6:1 are compared, against pa[21:16], so both halves are covered. Bit 8 gives the owner of the half with pa[15]=0, and bit 9 the owner of the half with pa[15]=1 (0 = data space, 1 = program space). The select asserts only if the owning space strobe is low and that space is not disabled (bit 13 disables program, bit 14 disables data).
- R6: Word j (j = 1 to 4) drives ext_sel_n[j-1]. Its bits 8:0 are compared against pa[21:13]. The select asserts when they match and at least one low strobe belongs to a space left enabled. Bit 13 disables program space, bit 14 data space and bit 15 I/O space.
- R7: Word 5 drives ext_sel_n[4]. Its bits 2:0 are compared against pa[15:13]. Only data space (disable bit 14) and I/O space (disable bit 15) qualify it, and program-space accesses never assert it.
- R8: While an access is in the window, every ext_sel_n bit is high, whatever the words contain.
- R9: Word 6 is stored, written and read back like the others, and it drives no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration state |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa | input | 22 | Primary address |
| ps_n | input | 1 | Program-space strobe, active low |
| ds_n | input | 1 | Data-space strobe, active low |
| is_n | input | 1 | I/O-space strobe, active low |
| iostrb_n | input | 1 | I/O access strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| pd | input | 16 | Primary data bus, register write data |
| sa_hi | input | 8 | Secondary address bits 15:8, window base source |
| prog | input | 1 | Programming strobe, base captured on its rise |
| int_sel_n | output | 1 | On-chip memory select, active low |
| ext_sel_n | output | 5 | External device selects, active low |
| rdata | output | 16 | Configuration word readback |

## Verification
The assertions assume that prog is held low through reset and changes only between clock edges. They also assume that the strobes, address and data settle between edges, so that sampled values are the ones the edge acts on. The stimulus drives every input just after a falling edge. It keeps prog low until after reset and asserts at most one space strobe at a time. Addresses are biased toward the programmed compare values and the register window, including a window that wraps past page 8'hFF.

// File: rtl/csdec.sv
module csdec #(
  parameter int NREG = 7,
  parameter int NEXT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [21:0] pa,
  input  logic        ps_n,
  input  logic        ds_n,
  input  logic        is_n,
  input  logic        iostrb_n,
  input  logic        rw,
  input  logic [15:0] pd,
  input  logic [7:0]  sa_hi,
  input  logic        prog,
  output logic        int_sel_n,
  output logic [4:0]  ext_sel_n,
  output logic [15:0] rdata
);

  logic [7:0]  base_q;
  logic        prog_q;
  logic [15:0] cfg [NREG];
  logic [7:0]  off;
  logic [2:0]  wr_idx;
  logic        reg_hit, wr_en;
  logic        sp_p, sp_d, sp_i;
  logic        int_match, int_owner, int_go;
  logic [NEXT-1:0] ext_hit;

  function automatic logic space_ok(logic [15:0] c, logic p, logic d, logic i);
    return (p && !c[13]) || (d && !c[14]) || (i && !c[15]);
  endfunction

  assign sp_p = !ps_n;
  assign sp_d = !ds_n;
  assign sp_i = !is_n;

  assign off     = pa[15:8] - base_q;
  assign wr_idx  = off[2:0];
  assign reg_hit = sp_i && (off < 8'(NREG));
  assign wr_en   = reg_hit && !iostrb_n && !rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      base_q <= 8'h00;
    end else begin
      prog_q <= prog;
      if (prog && !prog_q) base_q <= sa_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) cfg[k] <= 16'hFFFF;
    end else if (wr_en) begin
      cfg[wr_idx] <= pd;
    end
  end

  assign rdata = reg_hit ? cfg[wr_idx] : 16'h0000;

  assign int_match = cfg[0][7] ? (pa[21:16] == cfg[0][6:1]) : (pa[21:15] == cfg[0][6:0]);
  assign int_owner = pa[15] ? cfg[0][9] : cfg[0][8];
  assign int_go    = int_owner ? (sp_p && !cfg[0][13]) : (sp_d && !cfg[0][14]);
  assign int_sel_n = !(int_match && int_go);

  for (genvar g = 0; g < NEXT - 1; g++) begin : g_wide
    assign ext_hit[g] = (pa[21:13] == cfg[g+1][8:0]) && space_ok(cfg[g+1], sp_p, sp_d, sp_i);
  end

  assign ext_hit[NEXT-1] = (pa[15:13] == cfg[NEXT][2:0]) && space_ok(cfg[NEXT], 1'b0, sp_d, sp_i);

  assign ext_sel_n = ~(ext_hit & {NEXT{!reg_hit}});

endmodule

module csdec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ps_n,
  input logic        ds_n,
  input logic        is_n,
  input logic        prog,
  input logic [7:0]  sa_hi,
  input logic [15:0] pd,
  input logic        int_sel_n,
  input logic [4:0]  ext_sel_n,
  input logic [15:0] rdata,
  input logic        reg_hit,
  input logic        wr_en,
  input logic [2:0]  wr_idx,
  input logic [7:0]  base_q
);

  a_r2_base_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog) |=> base_q == $past(sa_hi));

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!(reg_hit && wr_idx == $past(wr_idx)) || rdata == $past(pd)));

  a_r3_quiet_readback: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |-> rdata == 16'h0000);

  a_r8_window_blocks_ext: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> &ext_sel_n);

  a_r5_int_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_n && ds_n) |-> int_sel_n);

  a_r7_ext4_no_program: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_n && is_n) |-> ext_sel_n[4]);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_n && ds_n && is_n) |-> (&ext_sel_n && int_sel_n));

endmodule

bind csdec csdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
  .prog(prog), .sa_hi(sa_hi), .pd(pd), .int_sel_n(int_sel_n),
  .ext_sel_n(ext_sel_n), .rdata(rdata), .reg_hit(reg_hit),
  .wr_en(wr_en), .wr_idx(wr_idx), .base_q(base_q)
);

// File: tb/csdec_bench.sv
module csdec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] pa = '0;
  logic        ps_n = 1'b1, ds_n = 1'b1, is_n = 1'b1, iostrb_n = 1'b1, rw = 1'b1;
  logic [15:0] pd = '0;
  logic [7:0]  sa_hi = '0;
  logic        prog = 1'b0;
  logic        int_sel_n;
  logic [4:0]  ext_sel_n;
  logic [15:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_cfg [7];
  logic [7:0]  m_base;

  always #10 clk = ~clk;

  csdec u_csdec (
    .clk(clk), .rst_n(rst_n), .pa(pa), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
    .iostrb_n(iostrb_n), .rw(rw), .pd(pd), .sa_hi(sa_hi), .prog(prog),
    .int_sel_n(int_sel_n), .ext_sel_n(ext_sel_n), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic in_win(logic [21:0] a, logic i_n);
    logic [7:0] d;
    d = a[15:8] - m_base;
    return !i_n && d < 8'd7;
  endfunction

  function automatic logic [15:0] exp_rdata(logic [21:0] a, logic i_n);
    logic [7:0] d;
    d = a[15:8] - m_base;
    return in_win(a, i_n) ? m_cfg[d[2:0]] : 16'h0000;
  endfunction

  function automatic logic exp_int(logic [21:0] a, logic p_n, logic d_n);
    logic hit, own;
    hit = m_cfg[0][7] ? (a[21:16] == m_cfg[0][6:1]) : (a[21:15] == m_cfg[0][6:0]);
    own = a[15] ? m_cfg[0][9] : m_cfg[0][8];
    if (own) return !(hit && !p_n && !m_cfg[0][13]);
    return !(hit && !d_n && !m_cfg[0][14]);
  endfunction

  function automatic logic [4:0] exp_ext(logic [21:0] a, logic p_n, logic d_n, logic i_n);
    logic [4:0] on;
    for (int j = 1; j <= 4; j++)
      on[j-1] = (a[21:13] == m_cfg[j][8:0]) &&
                ((!p_n && !m_cfg[j][13]) || (!d_n && !m_cfg[j][14]) || (!i_n && !m_cfg[j][15]));
    on[4] = (a[15:13] == m_cfg[5][2:0]) && ((!d_n && !m_cfg[5][14]) || (!i_n && !m_cfg[5][15]));
    if (in_win(a, i_n)) on = 5'b0;
    return ~on;
  endfunction

  task automatic drive(input logic [21:0] a, input int sp);
    @(negedge clk);
    pa = a; iostrb_n = 1'b1; rw = 1'b1;
    ps_n = (sp != 0); ds_n = (sp != 1); is_n = (sp != 2);
    #2;
  endtask

  task automatic check_all(input string tag);
    check({tag, " int"}, 32'(int_sel_n), 32'(exp_int(pa, ps_n, ds_n)));
    check({tag, " ext"}, 32'(ext_sel_n), 32'(exp_ext(pa, ps_n, ds_n, is_n)));
    check({tag, " rdata"}, 32'(rdata), 32'(exp_rdata(pa, is_n)));
  endtask

  task automatic set_base(input logic [7:0] b);
    @(negedge clk); sa_hi = b; prog = 1'b1;
    @(posedge clk); m_base = b;
    @(negedge clk); prog = 1'b0;
  endtask

  task automatic wr_reg(input int k, input logic [15:0] v, input logic strb_n, input logic rw_v);
    @(negedge clk);
    pa = {6'd0, 8'(m_base + 8'(k)), 8'h00};
    ps_n = 1'b1; ds_n = 1'b1; is_n = 1'b0; iostrb_n = strb_n; rw = rw_v; pd = v;
    @(posedge clk);
    if (!strb_n && !rw_v) m_cfg[k] = v;
    @(negedge clk); iostrb_n = 1'b1; rw = 1'b1; is_n = 1'b1;
  endtask

  task automatic rd_reg(input int k, input string tag);
    drive({6'd0, 8'(m_base + 8'(k)), 8'h00}, 2);
    check(tag, 32'(rdata), 32'(m_cfg[k]));
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd7351));
    for (int k = 0; k < 7; k++) m_cfg[k] = 16'hFFFF;
    m_base = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset int", 32'(int_sel_n), 32'd1);
    check("R1 reset ext", 32'(ext_sel_n), 32'h1F);
    check("R1 reset rdata", 32'(rdata), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 7; k++) rd_reg(k, "R1 reset word");

    set_base(8'h40);
    rd_reg(6, "R2 new base");
    drive(22'h000000, 2);
    check("R3 old base out of window", 32'(rdata), 32'h0);
    drive(22'h004700, 2);
    check("R3 base+7 outside", 32'(rdata), 32'h0);

    wr_reg(6, 16'h1234, 1'b0, 1'b0);
    rd_reg(6, "R9 word6 store");
    wr_reg(6, 16'hBEEF, 1'b0, 1'b1);
    rd_reg(6, "R4 read cycle ignored");
    wr_reg(6, 16'hBEEF, 1'b1, 1'b0);
    rd_reg(6, "R4 no strobe ignored");

    wr_reg(1, 16'hA005, 1'b0, 1'b0);
    drive({9'h005, 13'h1234}, 1);
    check("R6 ext0 data", 32'(ext_sel_n), 32'h1E);
    drive({9'h005, 13'h1234}, 0);
    check("R6 ext0 program off", 32'(ext_sel_n), 32'h1F);

    wr_reg(5, 16'h6003, 1'b0, 1'b0);
    drive(22'h006000, 2);
    check("R7 ext4 io", 32'(ext_sel_n), 32'h0F);
    drive(22'h006000, 0);
    check("R7 ext4 program never", 32'(ext_sel_n), 32'h1F);

    wr_reg(0, 16'h8203, 1'b0, 1'b0);
    drive({7'h03, 15'h0100}, 0);
    check("R5 upper half program", 32'(int_sel_n), 32'd0);
    drive({7'h03, 15'h0100}, 1);
    check("R5 upper half not data", 32'(int_sel_n), 32'd1);
    wr_reg(0, 16'h8284, 1'b0, 1'b0);
    drive({6'h02, 16'h0100}, 1);
    check("R5 span lower data", 32'(int_sel_n), 32'd0);
    drive({6'h02, 16'h8100}, 0);
    check("R5 span upper program", 32'(int_sel_n), 32'd0);

    set_base(8'h5F);
    drive(22'h006100, 2);
    check("R8 window blocks ext4", 32'(ext_sel_n), 32'h1F);
    check("R8 window readback", 32'(rdata), 32'(m_cfg[2]));

    set_base(8'hFC);
    wr_reg(6, 16'h0F0F, 1'b0, 1'b0);
    drive(22'h000200, 2);
    check("R3 wrapped window word6", 32'(rdata), 32'h0F0F);

    for (int it = 0; it < 400; it++) begin
      logic [21:0] a;
      int sel;
      if ($urandom % 10 == 0) set_base(8'($urandom));
      if ($urandom % 4 == 0)
        wr_reg($urandom % 7, 16'($urandom) & 16'h63FF, 1'b0, 1'b0);
      a = 22'($urandom);
      sel = $urandom % 4;
      case ($urandom % 4)
        0: a[21:13] = m_cfg[1 + $urandom % 4][8:0];
        1: a[15:13] = m_cfg[5][2:0];
        2: a[21:15] = m_cfg[0][6:0];
        default: a[15:8] = m_base + 8'($urandom % 8);
      endcase
      drive(a, sel);
      check_all("R6 R7 R5 R8 random");
    end

    finish_up();
  end

endmodule